// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block is a byte-wide bus peripheral that watches 48 input-only lines, arranged as six groups of eight. Software reads the live state of each group through an eight-byte register window and can ask the block to raise an interrupt whenever any line in a chosen group changes level, on either edge. Every line passes through a two-stage synchronizer before it is seen by the register bus or by the change detector.

One control register sits at the top of the window and has two roles. A write sets a six-bit group enable mask. A read returns the per-group change flags together with an active-low pending indication, so software on a shared interrupt line can tell whether this device raised it. That read also clears every latched flag. A change detected in the same cycle as the clearing read is kept for the next read. The interrupt is reported and enabled per group, not per line.

Top module: `cos_input_port`

## Requirements
- R1: After reset the enable mask and all change flags are zero, `irq` is 0 and a read of offset 7 returns 0x40.
- R2: Group g (0..5) reads at byte offset g for g<3 and g+1 for g>=3, so groups sit at offsets 0,1,2,4,5,6 in order. Bit n of that byte is line 8g+n, and it shows the synchronized input: a level driven before clock edge k is readable after edge k+1.
- R3: A read of offset 3 returns 0x00.
- R4: A write to offset 7 loads wdata[5:0] as the enable mask, where bit k enables group k. Writes to offsets 0 to 6 change neither the mask nor any flag.
- R5: A rising or a falling transition on any line of an enabled group k sets flag bit k and drives `irq` high.
- R6: Transitions in a disabled group set no flag and do not raise `irq`.
- R7: A read of offset 7 returns the flags in bits 5:0, the inverted interrupt state in bit 6 (0 = interrupt pending) and 0 in bit 7.
- R8: A read of offset 7 clears all flags and drops `irq` in the following cycle. A change detected on the clearing clock edge stays latched for the next read.
- R9: Clearing an enable bit also clears that group's flag.
- R10: `irq` is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 48 | Asynchronous input lines, line 8g+n is bit n of group g |
| addr | input | 3 | Byte offset within the register window |
| rd_en | input | 1 | Read strobe; a read of offset 7 clears the flags on the clock edge |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr`, combinational |
| irq | output | 1 | Active-high interrupt request |

## Verification
A single line is toggled, first rising and then falling, at every one of the 48 positions with all groups enabled. This separates the flag of each group from its neighbours and confirms that both edge directions are detected. The same toggles repeated with only the target group disabled show that the enable gates per group. Walking-one and complement patterns read at each data offset expose any swap of offsets or bits, including the gap at offset 3. A change timed so that its detection lands on the clearing read, together with clearing an enable while its flag is pending, covers the two ways a flag can be dropped or kept.

// File: rtl/cos_input_port.sv
module cos_input_port #(
  parameter int GROUPS = 6,
  parameter int GW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUPS*GW-1:0] din,
  input  logic [2:0]           addr,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 irq
);
  localparam int W = GROUPS * GW;
  localparam logic [2:0] CTRL = 3'd7;

  logic [W-1:0] meta, sync, prev;
  logic [GROUPS-1:0] en, flags, chg, flags_d, wmask;
  logic rd_ctrl, wr_ctrl;

  assign rd_ctrl = rd_en && addr == CTRL;
  assign wr_ctrl = wr_en && addr == CTRL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      prev <= '0;
    end else begin
      meta <= din;
      sync <= meta;
      prev <= sync;
    end
  end

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_grp
      assign chg[g] = |(sync[g*GW +: GW] ^ prev[g*GW +: GW]);
    end
  endgenerate

  assign wmask   = wr_ctrl ? wdata[GROUPS-1:0] : '1;
  assign flags_d = (((rd_ctrl ? '0 : flags) | chg) & en) & wmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= '0;
      flags <= '0;
    end else begin
      flags <= flags_d;
      if (wr_ctrl) en <= wdata[GROUPS-1:0];
    end
  end

  assign irq = |flags;

  always_comb begin
    rdata = 8'h00;
    if (addr == CTRL) begin
      rdata[GROUPS-1:0] = flags;
      rdata[6] = ~irq;
    end else begin
      for (int i = 0; i < GROUPS; i++)
        if ({29'd0, addr} == ((i < 3) ? i : i + 1))
          rdata = 8'(sync[i*GW +: GW]);
    end
  end
endmodule

module cos_input_port_chk #(
  parameter int GROUPS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic [GROUPS-1:0] en,
  input logic [GROUPS-1:0] flags,
  input logic [GROUPS-1:0] chg
);
  assert_enable_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7) |=> en == $past(wdata[GROUPS-1:0]));
  assert_enable_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd7) |=> $stable(en));
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~en) == '0);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd7 && !(wr_en && addr == 3'd7) && chg == '0) |=> !irq);
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|chg));
  assert_gap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd3) |-> rdata == 8'h00);
  assert_status_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd7) |-> (rdata[7] == 1'b0 && rdata[6] != irq));
endmodule

bind cos_input_port cos_input_port_chk #(.GROUPS(GROUPS)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .irq(irq), .en(en), .flags(flags), .chg(chg)
);

// File: tb/cos_input_port_tb.sv
module cos_input_port_tb_top;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [47:0] din = '0;
  logic [2:0] addr = '0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int tests = 0, fails = 0;
  logic [7:0] got;

  always #(PERIOD/2) clk = ~clk;

  cos_input_port dut_i (.clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  function automatic logic [2:0] off(int g);
    return 3'((g < 3) ? g : g + 1);
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(3'd7, got); check("R1 status", got, 8'h40);

    // R2 data mapping with walking ones and complements, R3 gap
    for (int g = 0; g < 6; g++)
      for (int b = 0; b < 8; b++) begin
        @(negedge clk); din = '0; din[g*8+b] = 1'b1;
        settle();
        for (int h = 0; h < 6; h++) begin
          rd(off(h), got);
          check("R2 walk", got, (h == g) ? 8'(1 << b) : 8'h00);
        end
        rd(3'd3, got); check("R3 gap", got, 8'h00);
      end
    @(negedge clk); din = 48'hA5C3_0F96_3C5A; settle();
    for (int h = 0; h < 6; h++) begin
      rd(off(h), got); check("R2 pattern", got, 8'(din >> (h*8)));
    end
    @(negedge clk); din = ~din; settle();
    for (int h = 0; h < 6; h++) begin
      rd(off(h), got); check("R2 complement", got, 8'(din >> (h*8)));
    end
    @(negedge clk); din = '0; settle();
    rd(3'd7, got); check("R6 no flags while disabled", got, 8'h40);

    // R4 writes to data offsets ignored (mask stays 0)
    for (int a = 0; a < 7; a++) wr(3'(a), 8'hFF);
    @(negedge clk); din = '1; settle();
    check("R4 no irq after data writes", {7'd0, irq}, 8'h00);
    rd(3'd7, got); check("R4 mask unchanged", got, 8'h40);
    @(negedge clk); din = '0; settle();

    // R5 / R7 / R8 / R10 per-line both edges, all enabled
    wr(3'd7, 8'h3F);
    for (int g = 0; g < 6; g++)
      for (int b = 0; b < 8; b++)
        for (int e = 0; e < 2; e++) begin
          @(negedge clk); din[g*8+b] = (e == 0);
          settle();
          check("R10 irq high", {7'd0, irq}, 8'h01);
          rd(3'd7, got); check("R5 R7 flag edge", got, 8'(1 << g));
          #1 check("R8 irq cleared", {7'd0, irq}, 8'h00);
          rd(3'd7, got); check("R8 status cleared", got, 8'h40);
        end

    // R6 disabled group only
    for (int g = 0; g < 6; g++) begin
      wr(3'd7, 8'h3F & ~8'(1 << g));
      @(negedge clk); din[g*8+3] = ~din[g*8+3];
      settle();
      check("R6 irq low", {7'd0, irq}, 8'h00);
      rd(3'd7, got); check("R6 no flag", got, 8'h40);
    end

    // R8 change detected on the clearing edge is kept
    wr(3'd7, 8'h3F);
    @(negedge clk); din[20] = ~din[20];
    @(posedge clk); @(posedge clk);
    rd(3'd7, got); check("R8 read before latch", got, 8'h40);
    rd(3'd7, got); check("R8 kept change", got, 8'h04);
    rd(3'd7, got); check("R8 then empty", got, 8'h40);

    // R9 clearing an enable drops that group's flag
    @(negedge clk); din[41] = ~din[41]; din[2] = ~din[2];
    settle();
    wr(3'd7, 8'h1F);
    #1 check("R9 irq stays for group 0", {7'd0, irq}, 8'h01);
    rd(3'd7, got); check("R9 group5 flag dropped", got, 8'h01);
    wr(3'd7, 8'h00);
    rd(3'd7, got); check("R9 all disabled", got, 8'h40);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule